// File: doc/BRIEF.md
# Reload Down-Counter Timer with Bus Registers

This block is a 32-bit down-counter that sits behind a zero-wait-state APB slave port. Software programs a reload value and a control word. While the timer is enabled it counts down one step per tick. The counter rests at zero for one tick after reaching it, then reloads. When the count steps from one to zero and interrupts are enabled, a sticky status bit is set. That bit drives the interrupt pin until software clears it with a write-one.

A single external pin can shape the tick in two ways. It can act as a run gate, so counting pauses while the pin is low. It can also act as a count clock, so one tick occurs per rising edge of the pin. Before use, the pin passes through a two-flop synchronizer and an edge detector. A bank of read-only identification bytes at the top of the 4 KiB window lets software recognise the block.

Top module: `apb_reload_timer`

## Requirements
- R1: Every APB transfer completes in its access phase: `pready` is high and `pslverr` is low whenever `psel` is high.
- R2: The word offsets are 0x000 control, 0x004 current count, 0x008 reload and 0x00C status. Control keeps only bits [3:0], which read back as written: bit0 run, bit1 gate by pin, bit2 count pin rising edges, bit3 interrupt enable.
- R3: A write to reload stores the value and also loads it into the counter.
- R4: A write to the count offset loads the counter and leaves reload unchanged.
- R5: With run set and neither pin mode selected, the count changes on every clock. With run clear, the count never changes except by a bus write.
- R6: The status bit (bit0 at 0x00C) is set on a 1-to-0 count step only when bit3 of control is set. `irq_o` always equals the status bit.
- R7: On the tick after reaching zero, the counter holds zero, and the next tick loads the reload value.
- R8: With reload zero, the counter stays at zero and no further interrupt is raised.
- R9: Writing 1 to status bit0 clears it. Writing 0 leaves it unchanged. A new set in the same cycle takes priority over the clear.
- R10: In gate mode (bit1 set, bit2 clear), ticks occur only while the synchronized pin is high.
- R11: In edge mode (bit2 set, whatever bit1 holds), exactly one tick occurs per rising edge of the pin, and the clock itself does not tick.
- R12: Offsets 0xFD0 to 0xFFC read the bytes 0x04,0x00,0x00,0x00,0x22,0xB8,0x1B,0x00,0x0D,0xF0,0x05,0xB1 in rising address order. Writes to them are ignored.
- R13: Any other offset, including one that is not word aligned, reads as zero, and writes to it are ignored.
- R14: After reset, control, status, reload and count are all zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | 12 | Byte address in window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data (valid during a read) |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| ext_in | input | 1 | Asynchronous gate / count pin |
| irq_o | output | 1 | Interrupt level |

## Verification
The assertions check the following on every cycle: the zero-wait bus response, that the interrupt rises only after a count of one with interrupts enabled, and that it falls only after a write-one to status. They also check the count's progress through one, then zero, then reload, that a stopped counter stays frozen, and that a zero reload locks the count at zero. Only the bench scenarios can show the register map contents, the identification bytes, the exact tick count in gate mode, and the one-tick-per-edge behaviour of the synchronized pin.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ID_N   = 12;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_RLD  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_STS  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_ID   = 12'hFD0;

  typedef struct packed {
    logic irq_en;
    logic pin_edge;
    logic pin_gate;
    logic run;
  } ctrl_t;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd0:    id_byte = 8'h04;
      4'd4:    id_byte = 8'h22;
      4'd5:    id_byte = 8'hB8;
      4'd6:    id_byte = 8'h1B;
      4'd8:    id_byte = 8'h0D;
      4'd9:    id_byte = 8'hF0;
      4'd10:   id_byte = 8'h05;
      4'd11:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= 1'b0;
        else        chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];

  assign level_o = chain[STAGES-1];
  assign rise_o  = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] count_o,
  output logic         fire_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (tick_i) begin
      if (cnt_q == '0)         cnt_q <= reload_i;
      else                     cnt_q <= cnt_q - ONE;
    end
  end

  assign count_o = cnt_q;
  assign fire_o  = tick_i & ~load_i & (cnt_q == ONE);
endmodule

// File: rtl/apb_reload_timer.sv
module apb_reload_timer
  import tmr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              ext_in,
  output logic              irq_o
);
  localparam int unsigned WA_W     = ADDR_W - 2;
  localparam logic [WA_W-1:0] ID_FIRST = OFF_ID[ADDR_W-1:2];
  localparam logic [WA_W-1:0] ID_LAST  = ID_FIRST + WA_W'(ID_N - 1);

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] rld_q;
  logic              sts_q;
  logic [DATA_W-1:0] cnt;
  logic              fire, tick, pin_lvl, pin_rise;
  logic              wr_acc, aligned, is_id;
  logic [WA_W-1:0]   wa, id_off;
  logic              hit_ctrl, hit_cnt, hit_rld, hit_sts;

  assign wr_acc   = psel & penable & pwrite;
  assign aligned  = (paddr[1:0] == 2'b00);
  assign wa       = paddr[ADDR_W-1:2];
  assign hit_ctrl = aligned && (paddr == OFF_CTRL);
  assign hit_cnt  = aligned && (paddr == OFF_CNT);
  assign hit_rld  = aligned && (paddr == OFF_RLD);
  assign hit_sts  = aligned && (paddr == OFF_STS);
  assign is_id    = aligned && (wa >= ID_FIRST) && (wa <= ID_LAST);
  assign id_off   = wa - ID_FIRST;

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(pclk), .rst_n(presetn), .pin_i(ext_in),
    .level_o(pin_lvl), .rise_o(pin_rise)
  );

  always_comb begin
    if (!ctrl_q.run)          tick = 1'b0;
    else if (ctrl_q.pin_edge) tick = pin_rise;
    else if (ctrl_q.pin_gate) tick = pin_lvl;
    else                      tick = 1'b1;
  end

  tmr_counter #(.W(DATA_W)) u_cnt (
    .clk(pclk), .rst_n(presetn), .tick_i(tick),
    .load_i(wr_acc & (hit_cnt | hit_rld)), .load_val_i(pwdata),
    .reload_i(rld_q), .count_o(cnt), .fire_o(fire)
  );

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctrl_q <= '0;
      rld_q  <= '0;
      sts_q  <= 1'b0;
    end else begin
      if (wr_acc && hit_ctrl) ctrl_q <= ctrl_t'(pwdata[3:0]);
      if (wr_acc && hit_rld)  rld_q  <= pwdata;
      if (fire && ctrl_q.irq_en)             sts_q <= 1'b1;
      else if (wr_acc && hit_sts && pwdata[0]) sts_q <= 1'b0;
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (hit_ctrl)     prdata = DATA_W'(ctrl_q);
      else if (hit_cnt) prdata = cnt;
      else if (hit_rld) prdata = rld_q;
      else if (hit_sts) prdata = DATA_W'(sts_q);
      else if (is_id)   prdata = DATA_W'(id_byte(id_off[3:0]));
    end
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign irq_o   = sts_q;
endmodule

// File: rtl/apb_reload_timer_chk.sv
module apb_reload_timer_chk
  import tmr_pkg::*;
(
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic              wdat0,
  input logic              pready,
  input logic              pslverr,
  input logic              irq_o,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] rld,
  input logic              run,
  input logic              irq_en,
  input logic              tick
);
  logic wr;
  assign wr = psel & penable & pwrite;

  p_zero_wait_r1: assert property (@(posedge pclk) disable iff (!presetn)
    psel |-> (pready && !pslverr));

  p_stopped_r5: assert property (@(posedge pclk) disable iff (!presetn)
    (!run && !wr) |=> $stable(cnt));

  p_irq_source_r6: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(irq_o) |-> ($past(cnt) == 1 && $past(irq_en) && $past(tick)));

  p_one_to_zero_r7: assert property (@(posedge pclk) disable iff (!presetn)
    (tick && cnt == 1 && !wr) |=> (cnt == 0));

  p_zero_reloads_r7: assert property (@(posedge pclk) disable iff (!presetn)
    (tick && cnt == 0 && !wr) |=> (cnt == $past(rld)));

  p_zero_lock_r8: assert property (@(posedge pclk) disable iff (!presetn)
    (cnt == 0 && rld == 0 && !wr) |=> (cnt == 0 && !$rose(irq_o)));

  p_clear_source_r9: assert property (@(posedge pclk) disable iff (!presetn)
    $fell(irq_o) |-> $past(wr && paddr == OFF_STS && wdat0));
endmodule

bind apb_reload_timer apb_reload_timer_chk u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .wdat0(pwdata[0]), .pready(pready),
  .pslverr(pslverr), .irq_o(irq_o), .cnt(cnt), .rld(rld_q),
  .run(ctrl_q.run), .irq_en(ctrl_q.irq_en), .tick(tick)
);

// File: tb/test_apb_reload_timer.sv
module test_apb_reload_timer;
  logic        pclk = 1'b0, presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, ext_in = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata, rd;
  logic        pready, pslverr, irq_o;
  int          n_chk = 0, n_bad = 0;

  always #5 pclk = ~pclk;

  apb_reload_timer i_apb_reload_timer (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .ext_in(ext_in), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] a;
    logic [31:0] d;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 12'h008, 32'h12345678, 4'd3},  // R3 reload write
    '{1'b0, 12'h004, 32'h12345678, 4'd3},  // R3 counter loaded too
    '{1'b0, 12'h008, 32'h12345678, 4'd3},
    '{1'b1, 12'h004, 32'h00000007, 4'd4},  // R4 count write
    '{1'b0, 12'h004, 32'h00000007, 4'd4},
    '{1'b0, 12'h008, 32'h12345678, 4'd4},  // R4 reload untouched
    '{1'b1, 12'h000, 32'hFFFFFFF6, 4'd2},  // R2 only [3:0] kept
    '{1'b0, 12'h000, 32'h00000006, 4'd2},
    '{1'b0, 12'h004, 32'h00000007, 4'd5},  // R5 stopped: no change
    '{1'b0, 12'hFD0, 32'h00000004, 4'd12}, // R12 identification
    '{1'b0, 12'hFD4, 32'h00000000, 4'd12},
    '{1'b0, 12'hFE0, 32'h00000022, 4'd12},
    '{1'b0, 12'hFE4, 32'h000000B8, 4'd12},
    '{1'b0, 12'hFE8, 32'h0000001B, 4'd12},
    '{1'b0, 12'hFF0, 32'h0000000D, 4'd12},
    '{1'b0, 12'hFF4, 32'h000000F0, 4'd12},
    '{1'b0, 12'hFF8, 32'h00000005, 4'd12},
    '{1'b0, 12'hFFC, 32'h000000B1, 4'd12},
    '{1'b1, 12'hFE0, 32'h000000FF, 4'd12},
    '{1'b0, 12'hFE0, 32'h00000022, 4'd12}, // R12 write ignored
    '{1'b1, 12'h100, 32'h00000005, 4'd13}, // R13 unmapped
    '{1'b0, 12'h100, 32'h00000000, 4'd13},
    '{1'b0, 12'h006, 32'h00000000, 4'd13}, // R13 misaligned
    '{1'b1, 12'h000, 32'h00000000, 4'd2}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the second rising edge
  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk) penable = 1'b1;
    @(negedge pclk) begin psel = 1'b0; penable = 1'b0; pwrite = 1'b0; end
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk) penable = 1'b1;
    #1 d = prdata;
    check("R1 pready/pslverr", {30'd0, pready, pslverr}, 32'h2);
    @(negedge pclk) begin psel = 1'b0; penable = 1'b0; end
  endtask

  initial begin
    repeat (20000) @(posedge pclk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);

    // R14 reset state
    check("R14 irq after reset", {31'd0, irq_o}, 32'd0);
    rd_reg(12'h000, rd); check("R14 control", rd, 0);
    rd_reg(12'h004, rd); check("R14 count", rd, 0);
    rd_reg(12'h008, rd); check("R14 reload", rd, 0);
    rd_reg(12'h00C, rd); check("R14 status", rd, 0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) wr_reg(TBL[i].a, TBL[i].d);
      else begin
        rd_reg(TBL[i].a, rd);
        check($sformatf("R%0d table entry %0d", TBL[i].req, i), rd, TBL[i].d);
      end
    end

    // R5 R6 R7: reload 3, enable with irq; fire 3 ticks later, hold, reload
    wr_reg(12'h008, 32'd3);
    wr_reg(12'h000, 32'h9);
    repeat (2) @(negedge pclk);
    check("R6 no irq before 1->0", {31'd0, irq_o}, 0);
    @(negedge pclk);
    check("R6 irq on 1->0", {31'd0, irq_o}, 1);
    wr_reg(12'h000, 32'h8);           // two more ticks: hold 0, reload 3, then 2
    rd_reg(12'h004, rd); check("R7 hold then reload", rd, 32'd2);
    rd_reg(12'h00C, rd); check("R6 status mirrors irq", rd, 32'd1);

    // R9 write-one-to-clear
    wr_reg(12'h00C, 32'h0);
    check("R9 write 0 keeps irq", {31'd0, irq_o}, 1);
    wr_reg(12'h00C, 32'h1);
    check("R9 write 1 clears irq", {31'd0, irq_o}, 0);

    // R6 interrupt enable clear blocks status
    wr_reg(12'h008, 32'd2);
    wr_reg(12'h000, 32'h1);
    repeat (10) @(negedge pclk);
    check("R6 no irq when disabled", {31'd0, irq_o}, 0);
    wr_reg(12'h000, 32'h0);

    // R8 zero reload: one fire from count 1, then nothing
    wr_reg(12'h008, 32'd0);
    wr_reg(12'h000, 32'h9);
    wr_reg(12'h004, 32'd1);
    @(negedge pclk);
    check("R8 fire from written 1", {31'd0, irq_o}, 1);
    wr_reg(12'h00C, 32'h1);
    repeat (10) @(negedge pclk);
    check("R8 no re-trigger", {31'd0, irq_o}, 0);
    rd_reg(12'h004, rd); check("R8 count stays zero", rd, 0);
    wr_reg(12'h000, 32'h0);

    // R10 gate mode, pin low: frozen
    ext_in = 1'b0; repeat (5) @(negedge pclk);
    wr_reg(12'h008, 32'd5);
    wr_reg(12'h000, 32'h3);
    repeat (10) @(negedge pclk);
    wr_reg(12'h000, 32'h0);
    rd_reg(12'h004, rd); check("R10 gate low pauses", rd, 32'd5);

    // R10 gate mode, pin high: 12 ticks
    ext_in = 1'b1; repeat (5) @(negedge pclk);
    wr_reg(12'h008, 32'd100);
    wr_reg(12'h000, 32'h3);
    repeat (10) @(negedge pclk);
    wr_reg(12'h000, 32'h0);
    rd_reg(12'h004, rd); check("R10 gate high counts", rd, 32'd88);

    // R11 edge mode (gate bit also set): four pulses, four ticks
    ext_in = 1'b0; repeat (5) @(negedge pclk);
    wr_reg(12'h008, 32'd100);
    wr_reg(12'h000, 32'h7);
    for (int p = 0; p < 4; p++) begin
      ext_in = 1'b1; repeat (3) @(negedge pclk);
      ext_in = 1'b0; repeat (3) @(negedge pclk);
    end
    repeat (5) @(negedge pclk);
    wr_reg(12'h000, 32'h0);
    rd_reg(12'h004, rd); check("R11 one tick per edge", rd, 32'd96);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule